// File: doc/BRIEF.md
# Timeout-Ordered Task Wait Queue

This block keeps the tasks that are sleeping until a deadline. There is one queue per priority lane. Lane 0 is the high-priority lane and counts microsecond ticks. Lane 1 is the low-priority lane and counts millisecond ticks. Each lane owns a 32-bit wrap-around time counter that advances on its own tick input.

A scheduler makes a wait request with the workspace pointer of a task. The deadline of that task is already stored in memory at byte offset 16 of its workspace. The block reads the deadline. If the deadline is already reached, the task is not queued. Otherwise the block walks a singly linked list through a shared memory port, one access per cycle, and links the task in deadline order. The link word sits at byte offset 12 of each workspace.

Only the head entry of each lane is compared with that lane's counter, and the comparison runs every cycle. When the head's deadline is reached, the block presents that task on a one-cycle release strobe toward the ready queue of the same priority. It then reads the next link to advance the head.

Top module: `tq_timer_queue`

## Requirements
- R1: After reset both lanes are empty, both counters read zero, `wait_ready_o` is high, and `exp_valid_o`, `wait_done_o` and `mem_req_o` are low.
- R2: Lane i's counter (`now_o[32*i +: 32]`) increments by one, modulo 2^32, on each cycle where `tick_i[i]` is high, and holds otherwise.
- R3: A wait request reads the deadline D at workspace+16. If the 32-bit difference D minus now, read as signed, is zero or negative, the block reports `wait_done_o` with `wait_queued_o` low. It never releases the task and writes no link word. Address 0 is the null link; workspaces are nonzero and word aligned.
- R4: A difference from 1 to 0x7FFFFFFF counts as future and queues the task (`wait_queued_o` high). A difference of 0x80000000 counts as not future.
- R5: Within one lane, tasks are released in ascending deadline order. Tasks with equal deadlines are released in the order of their wait requests.
- R6: The link word at workspace+12 of each queued task holds the pointer to the next-later task in its lane. The last task's link holds 0.
- R7: A head task is released while its lane counter equals or has passed its deadline. When ticks are at least 8 cycles apart, it is released before the next tick, so the counter at release equals the deadline.
- R8: A release is a single-cycle `exp_valid_o` pulse carrying a nonzero `exp_wptr_o` and its lane on `exp_prio_o`. Two releases never occur in consecutive cycles.
- R9: The lanes are independent: ticks on one lane never release a task of the other lane. When both heads are due, lane 0 is released first.
- R10: A due head is released before any new wait request is accepted: `wait_ready_o` is low in every cycle where `exp_valid_o` is high.
- R11: One wait request is handled at a time. `wait_ready_o` stays low from acceptance until `wait_done_o`, and `wait_done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | NPRIO | Per-lane time tick (bit 0 microsecond, bit 1 millisecond) |
| now_o | output | NPRIO*TIME_W | Per-lane time counters, lane i at bits [TIME_W*i +: TIME_W] |
| wait_valid_i | input | 1 | Wait request present |
| wait_ready_o | output | 1 | Wait request accepted this cycle when valid |
| wait_prio_i | input | PW | Lane of the waiting task |
| wait_wptr_i | input | ADDR_W | Workspace pointer of the waiting task |
| wait_done_o | output | 1 | Wait handling finished (one-cycle pulse) |
| wait_queued_o | output | 1 | With done: task was queued |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | TIME_W | Write data |
| mem_rdata_i | input | TIME_W | Read data, valid the cycle after a read request |
| exp_valid_o | output | 1 | Task released to the ready queue |
| exp_prio_o | output | PW | Lane of the released task |
| exp_wptr_o | output | ADDR_W | Workspace pointer of the released task |

## Verification
A wrong cached head pointer or deadline shows up at the release strobe. The task comes out early, late, or out of order, and the bench records this in the cycle of the release by comparing the lane counter with the task's deadline. A broken list walk shows up in the link words written to memory. The bench reads these back as soon as the inserts finish, before any tick, so a misplaced entry is found before it can affect release order. A lost lane selection appears as a release on the wrong `exp_prio_o`, or as a release caused by the other lane's ticks.

// File: rtl/tq_pkg.sv
package tq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POP_NXT,
      ST_POP_TM,
      ST_INS_DEC,
      ST_WLK_NXT,
      ST_WLK_TM,
      ST_WR_LINK
   } tq_state_e;
endpackage

// File: rtl/tq_lane_timer.sv
module tq_lane_timer #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   output logic [TIME_W-1:0] now
);
   always_ff @(posedge clk) begin
      if (!rst_n)    now <= '0;
      else if (tick) now <= now + 1'b1;
   end
endmodule

// File: rtl/tq_lane_head.sv
module tq_lane_head #(
   parameter int ADDR_W = 16,
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_ptr,
   input  logic [ADDR_W-1:0] ptr_d,
   input  logic              set_time,
   input  logic [TIME_W-1:0] time_d,
   input  logic              drop,
   input  logic [TIME_W-1:0] now,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [TIME_W-1:0] time_q,
   output logic              valid_q,
   output logic              expired
);
   logic [TIME_W-1:0] diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         time_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (set_ptr) ptr_q <= ptr_d;
         if (set_time) begin
            time_q  <= time_d;
            valid_q <= 1'b1;
         end else if (drop) begin
            valid_q <= 1'b0;
         end
      end
   end

   // due when deadline minus now is zero or negative as a signed value
   assign diff    = time_q - now;
   assign expired = valid_q && (diff[TIME_W-1] || (diff == '0));
endmodule

// File: rtl/tq_ctrl.sv
module tq_ctrl
   import tq_pkg::*;
#(
   parameter int NPRIO    = 2,
   parameter int ADDR_W   = 16,
   parameter int TIME_W   = 32,
   parameter int LINK_OFS = 12,
   parameter int TIME_OFS = 16,
   parameter int PW       = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPRIO-1:0][TIME_W-1:0] now,
   input  logic [NPRIO-1:0][ADDR_W-1:0] hptr,
   input  logic [NPRIO-1:0][TIME_W-1:0] htime,
   input  logic [NPRIO-1:0]             hvalid,
   input  logic [NPRIO-1:0]             expired,
   output logic [NPRIO-1:0]             set_ptr,
   output logic [NPRIO-1:0]             set_time,
   output logic [NPRIO-1:0]             drop,
   output logic [ADDR_W-1:0]            ptr_d,
   output logic [TIME_W-1:0]            time_d,
   input  logic                         wait_valid_i,
   output logic                         wait_ready_o,
   input  logic [PW-1:0]                wait_prio_i,
   input  logic [ADDR_W-1:0]            wait_wptr_i,
   output logic                         wait_done_o,
   output logic                         wait_queued_o,
   output logic                         mem_req_o,
   output logic                         mem_we_o,
   output logic [ADDR_W-1:0]            mem_addr_o,
   output logic [TIME_W-1:0]            mem_wdata_o,
   input  logic [TIME_W-1:0]            mem_rdata_i,
   output logic                         exp_valid_o,
   output logic [PW-1:0]                exp_prio_o,
   output logic [ADDR_W-1:0]            exp_wptr_o
);
   localparam logic [ADDR_W-1:0] LINK_A = ADDR_W'(LINK_OFS);
   localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(TIME_OFS);

   tq_state_e         st, st_d;
   logic [PW-1:0]     cur_p, cur_p_d, pick;
   logic [ADDR_W-1:0] new_ptr, new_ptr_d, prev, prev_d, nxt, nxt_d, rd_ptr;
   logic [TIME_W-1:0] new_time, new_time_d;
   logic              fin, fin_q, any_exp;

   function automatic logic is_future(input logic [TIME_W-1:0] t, input logic [TIME_W-1:0] n);
      logic [TIME_W-1:0] d;
      d = t - n;
      return !d[TIME_W-1] && (d != '0);
   endfunction

   function automatic logic is_before(input logic [TIME_W-1:0] a, input logic [TIME_W-1:0] b);
      logic [TIME_W-1:0] d;
      d = a - b;
      return d[TIME_W-1];
   endfunction

   assign rd_ptr  = mem_rdata_i[ADDR_W-1:0];
   assign any_exp = |expired;

   always_comb begin
      pick = '0;
      for (int i = NPRIO - 1; i >= 0; i--) if (expired[i]) pick = PW'(i);
   end

   always_comb begin
      st_d = st; cur_p_d = cur_p; new_ptr_d = new_ptr; new_time_d = new_time;
      prev_d = prev; nxt_d = nxt;
      mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0; mem_wdata_o = '0;
      set_ptr = '0; set_time = '0; drop = '0; ptr_d = '0; time_d = '0;
      exp_valid_o = 1'b0; exp_prio_o = pick; exp_wptr_o = hptr[pick];
      wait_ready_o = 1'b0; fin = 1'b0; fin_q = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (any_exp) begin
               exp_valid_o = 1'b1;
               mem_req_o   = 1'b1;
               mem_addr_o  = hptr[pick] + LINK_A;
               cur_p_d     = pick;
               st_d        = ST_POP_NXT;
            end else begin
               wait_ready_o = 1'b1;
               if (wait_valid_i) begin
                  mem_req_o  = 1'b1;
                  mem_addr_o = wait_wptr_i + TIME_A;
                  cur_p_d    = wait_prio_i;
                  new_ptr_d  = wait_wptr_i;
                  st_d       = ST_INS_DEC;
               end
            end
         end
         ST_POP_NXT: begin
            drop[cur_p] = 1'b1; set_ptr[cur_p] = 1'b1; ptr_d = rd_ptr;
            if (rd_ptr != '0) begin
               mem_req_o  = 1'b1;
               mem_addr_o = rd_ptr + TIME_A;
               st_d       = ST_POP_TM;
            end else st_d = ST_IDLE;
         end
         ST_POP_TM: begin
            set_time[cur_p] = 1'b1; time_d = mem_rdata_i;
            st_d = ST_IDLE;
         end
         ST_INS_DEC: begin
            new_time_d = mem_rdata_i;
            if (!is_future(mem_rdata_i, now[cur_p])) begin
               fin = 1'b1;
               st_d = ST_IDLE;
            end else if (!hvalid[cur_p] || is_before(mem_rdata_i, htime[cur_p])) begin
               mem_req_o = 1'b1; mem_we_o = 1'b1;
               mem_addr_o  = new_ptr + LINK_A;
               mem_wdata_o = TIME_W'(hptr[cur_p]);
               set_ptr[cur_p] = 1'b1; ptr_d = new_ptr;
               set_time[cur_p] = 1'b1; time_d = mem_rdata_i;
               fin = 1'b1; fin_q = 1'b1;
               st_d = ST_IDLE;
            end else begin
               mem_req_o  = 1'b1;
               mem_addr_o = hptr[cur_p] + LINK_A;
               prev_d     = hptr[cur_p];
               st_d       = ST_WLK_NXT;
            end
         end
         ST_WLK_NXT: begin
            nxt_d = rd_ptr;
            mem_req_o = 1'b1;
            if (rd_ptr == '0) begin
               mem_we_o = 1'b1; mem_addr_o = prev + LINK_A;
               mem_wdata_o = TIME_W'(new_ptr);
               st_d = ST_WR_LINK;
            end else begin
               mem_addr_o = rd_ptr + TIME_A;
               st_d = ST_WLK_TM;
            end
         end
         ST_WLK_TM: begin
            mem_req_o = 1'b1;
            if (is_before(new_time, mem_rdata_i)) begin
               mem_we_o = 1'b1; mem_addr_o = prev + LINK_A;
               mem_wdata_o = TIME_W'(new_ptr);
               st_d = ST_WR_LINK;
            end else begin
               mem_addr_o = nxt + LINK_A;
               prev_d = nxt;
               st_d = ST_WLK_NXT;
            end
         end
         ST_WR_LINK: begin
            mem_req_o = 1'b1; mem_we_o = 1'b1;
            mem_addr_o = new_ptr + LINK_A;
            mem_wdata_o = TIME_W'(nxt);
            fin = 1'b1; fin_q = 1'b1;
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; cur_p <= '0; new_ptr <= '0; new_time <= '0;
         prev <= '0; nxt <= '0; wait_done_o <= 1'b0; wait_queued_o <= 1'b0;
      end else begin
         st <= st_d; cur_p <= cur_p_d; new_ptr <= new_ptr_d; new_time <= new_time_d;
         prev <= prev_d; nxt <= nxt_d;
         wait_done_o <= fin; wait_queued_o <= fin_q;
      end
   end
endmodule

// File: rtl/tq_timer_queue.sv
module tq_timer_queue #(
   parameter int NPRIO    = 2,
   parameter int ADDR_W   = 16,
   parameter int TIME_W   = 32,
   parameter int LINK_OFS = 12,
   parameter int TIME_OFS = 16,
   localparam int PW      = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPRIO-1:0]        tick_i,
   output logic [NPRIO*TIME_W-1:0] now_o,
   input  logic                    wait_valid_i,
   output logic                    wait_ready_o,
   input  logic [PW-1:0]           wait_prio_i,
   input  logic [ADDR_W-1:0]       wait_wptr_i,
   output logic                    wait_done_o,
   output logic                    wait_queued_o,
   output logic                    mem_req_o,
   output logic                    mem_we_o,
   output logic [ADDR_W-1:0]       mem_addr_o,
   output logic [TIME_W-1:0]       mem_wdata_o,
   input  logic [TIME_W-1:0]       mem_rdata_i,
   output logic                    exp_valid_o,
   output logic [PW-1:0]           exp_prio_o,
   output logic [ADDR_W-1:0]       exp_wptr_o
);
   initial begin
      assert (NPRIO >= 1) else $error("NPRIO must be at least 1");
      assert (ADDR_W <= TIME_W) else $error("ADDR_W must not exceed TIME_W");
      assert (LINK_OFS % 4 == 0 && TIME_OFS % 4 == 0) else $error("offsets must be word aligned");
   end

   logic [NPRIO-1:0][TIME_W-1:0] now, htime;
   logic [NPRIO-1:0][ADDR_W-1:0] hptr;
   logic [NPRIO-1:0]             hvalid, expired, set_ptr, set_time, drop;
   logic [ADDR_W-1:0]            ptr_d;
   logic [TIME_W-1:0]            time_d;

   assign now_o = now;

   for (genvar g = 0; g < NPRIO; g++) begin : g_lane
      tq_lane_timer #(.TIME_W(TIME_W)) timer_i (
         .clk(clk), .rst_n(rst_n), .tick(tick_i[g]), .now(now[g]));
      tq_lane_head #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) head_i (
         .clk(clk), .rst_n(rst_n), .set_ptr(set_ptr[g]), .ptr_d(ptr_d),
         .set_time(set_time[g]), .time_d(time_d), .drop(drop[g]), .now(now[g]),
         .ptr_q(hptr[g]), .time_q(htime[g]), .valid_q(hvalid[g]), .expired(expired[g]));
   end

   tq_ctrl #(.NPRIO(NPRIO), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .LINK_OFS(LINK_OFS),
             .TIME_OFS(TIME_OFS), .PW(PW)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .now(now), .hptr(hptr), .htime(htime),
      .hvalid(hvalid), .expired(expired), .set_ptr(set_ptr), .set_time(set_time),
      .drop(drop), .ptr_d(ptr_d), .time_d(time_d),
      .wait_valid_i(wait_valid_i), .wait_ready_o(wait_ready_o),
      .wait_prio_i(wait_prio_i), .wait_wptr_i(wait_wptr_i),
      .wait_done_o(wait_done_o), .wait_queued_o(wait_queued_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .exp_valid_o(exp_valid_o), .exp_prio_o(exp_prio_o), .exp_wptr_o(exp_wptr_o));
endmodule

// File: rtl/tq_timer_queue_chk.sv
module tq_timer_queue_chk #(
   parameter int NPRIO  = 2,
   parameter int ADDR_W = 16,
   parameter int TIME_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPRIO-1:0]        tick_i,
   input logic [NPRIO*TIME_W-1:0] now_o,
   input logic                    wait_ready_o,
   input logic                    wait_done_o,
   input logic                    wait_queued_o,
   input logic                    exp_valid_o,
   input logic [ADDR_W-1:0]       exp_wptr_o
);
   for (genvar g = 0; g < NPRIO; g++) begin : g_lane
      AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         tick_i[g] |=> now_o[g*TIME_W +: TIME_W] == TIME_W'($past(now_o[g*TIME_W +: TIME_W]) + 1'b1)); // R2
      AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !tick_i[g] |=> $stable(now_o[g*TIME_W +: TIME_W])); // R2
   end

   AST_QUEUED_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_queued_o |-> wait_done_o); // R3
   AST_EXP_NONNULL: assert property (@(posedge clk) disable iff (!rst_n)
      exp_valid_o |-> exp_wptr_o != '0); // R8
   AST_EXP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      exp_valid_o |=> !exp_valid_o); // R8
   AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      exp_valid_o |-> !wait_ready_o); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_done_o |=> !wait_done_o); // R11
endmodule

bind tq_timer_queue tq_timer_queue_chk #(.NPRIO(NPRIO), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .now_o(now_o),
   .wait_ready_o(wait_ready_o), .wait_done_o(wait_done_o),
   .wait_queued_o(wait_queued_o), .exp_valid_o(exp_valid_o), .exp_wptr_o(exp_wptr_o));

// File: tb/tq_timer_queue_tb_top.sv
module tq_timer_queue_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  tick_i = '0;
   logic [63:0] now_o;
   logic        wait_valid_i = 1'b0, wait_ready_o;
   logic [0:0]  wait_prio_i = '0;
   logic [15:0] wait_wptr_i = '0;
   logic        wait_done_o, wait_queued_o;
   logic        mem_req_o, mem_we_o;
   logic [15:0] mem_addr_o;
   logic [31:0] mem_wdata_o, mem_rdata_i;
   logic        exp_valid_o;
   logic [0:0]  exp_prio_o;
   logic [15:0] exp_wptr_o;

   logic [31:0] mem [0:255];
   int          n_chk = 0, n_err = 0, ev_n = 0;
   logic [15:0] ev_ptr [0:15];
   logic        ev_prio [0:15];
   logic [31:0] ev_now [0:15];
   logic        prev_exp = 1'b0;

   always #5 clk = ~clk;

   tq_timer_queue dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .now_o(now_o),
      .wait_valid_i(wait_valid_i), .wait_ready_o(wait_ready_o),
      .wait_prio_i(wait_prio_i), .wait_wptr_i(wait_wptr_i),
      .wait_done_o(wait_done_o), .wait_queued_o(wait_queued_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .exp_valid_o(exp_valid_o), .exp_prio_o(exp_prio_o), .exp_wptr_o(exp_wptr_o));

   always @(posedge clk) begin
      if (mem_req_o) begin
         if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
         else          mem_rdata_i <= mem[mem_addr_o[9:2]];
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // release monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (exp_valid_o) begin
            chk(!prev_exp, "R8", "back-to-back release", 1, 0);
            chk(!wait_ready_o, "R10", "ready during release", longint'(wait_ready_o), 0);
            if (ev_n < 16) begin
               ev_ptr[ev_n]  = exp_wptr_o;
               ev_prio[ev_n] = exp_prio_o[0];
               ev_now[ev_n]  = exp_prio_o[0] ? now_o[63:32] : now_o[31:0];
            end
            ev_n++;
         end
         prev_exp = exp_valid_o;
      end
   end

   task automatic do_wait(input logic prio, input logic [15:0] wp, input logic [31:0] dl,
                          output logic queued);
      mem[wp[9:2] + 8'd4] = dl;
      @(negedge clk);
      wait_valid_i = 1'b1; wait_prio_i = prio; wait_wptr_i = wp;
      while (!wait_ready_o) @(negedge clk);
      @(negedge clk);
      wait_valid_i = 1'b0;
      chk(!wait_ready_o, "R11", "ready while busy", longint'(wait_ready_o), 0);
      queued = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (wait_done_o) begin
            queued = wait_queued_o;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic tick(input logic [1:0] m, input int gap);
      @(negedge clk); tick_i = m;
      @(negedge clk); tick_i = '0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(wait_ready_o == 1'b1, "R1", "ready", longint'(wait_ready_o), 1);
      chk(!exp_valid_o && !wait_done_o, "R1", "strobes", longint'({exp_valid_o, wait_done_o}), 0);
      chk(!mem_req_o, "R1", "mem idle", longint'(mem_req_o), 0);
      chk(now_o == '0, "R1", "counters", longint'(now_o), 0);
   endtask

   task automatic t_not_future;
      logic q;
      mem[8'hC3] = 32'hDEAD;
      do_wait(1'b0, 16'h0300, 32'h0, q);
      chk(q == 1'b0, "R3", "equal deadline queued", longint'(q), 0);
      do_wait(1'b0, 16'h0300, 32'hFFFF_FFF0, q);
      chk(q == 1'b0, "R3", "past deadline queued", longint'(q), 0);
      repeat (5) @(negedge clk);
      chk(mem[8'hC3] == 32'hDEAD, "R3", "link written", longint'(mem[8'hC3]), 32'hDEAD);
      chk(ev_n == 0, "R3", "release count", ev_n, 0);
   endtask

   task automatic t_sorted;
      logic q;
      do_wait(1'b0, 16'h0100, 32'd50, q); chk(q, "R4", "A queued", longint'(q), 1);
      do_wait(1'b0, 16'h0140, 32'd20, q); chk(q, "R4", "B queued", longint'(q), 1);
      do_wait(1'b0, 16'h0180, 32'd35, q); chk(q, "R4", "C queued", longint'(q), 1);
      do_wait(1'b0, 16'h01C0, 32'd20, q); chk(q, "R4", "D queued", longint'(q), 1);
      @(negedge clk);
      chk(mem[8'h53] == 32'h01C0, "R6", "link B", longint'(mem[8'h53]), 32'h01C0);
      chk(mem[8'h73] == 32'h0180, "R6", "link D", longint'(mem[8'h73]), 32'h0180);
      chk(mem[8'h63] == 32'h0100, "R6", "link C", longint'(mem[8'h63]), 32'h0100);
      chk(mem[8'h43] == 32'h0,    "R6", "link A", longint'(mem[8'h43]), 0);
      for (int i = 0; i < 60; i++) tick(2'b01, 8);
      chk(ev_n == 4, "R5", "release count", ev_n, 4);
      chk(ev_ptr[0] == 16'h0140 && ev_ptr[1] == 16'h01C0, "R5", "equal order",
          longint'({ev_ptr[0], ev_ptr[1]}), 64'h014001C0);
      chk(ev_ptr[2] == 16'h0180 && ev_ptr[3] == 16'h0100, "R5", "later order",
          longint'({ev_ptr[2], ev_ptr[3]}), 64'h01800100);
      chk(ev_now[0] == 20 && ev_now[1] == 20, "R7", "now at release 0/1",
          longint'({ev_now[0], ev_now[1]}), 64'h0000001400000014);
      chk(ev_now[2] == 35 && ev_now[3] == 50, "R7", "now at release 2/3",
          longint'({ev_now[2], ev_now[3]}), 64'h0000002300000032);
      chk(ev_prio[0] == 1'b0, "R8", "release lane", longint'(ev_prio[0]), 0);
      chk(now_o[31:0] == 60 && now_o[63:32] == 0, "R2", "counters", longint'(now_o), 60);
   endtask

   task automatic t_lanes;
      logic q;
      do_wait(1'b1, 16'h0200, 32'd3, q);  chk(q, "R9", "low queued", longint'(q), 1);
      do_wait(1'b0, 16'h0240, 32'd62, q); chk(q, "R9", "high queued", longint'(q), 1);
      tick(2'b01, 8);
      tick(2'b10, 8);
      tick(2'b10, 8);
      chk(ev_n == 4, "R9", "early release", ev_n, 4);
      tick(2'b11, 12);
      chk(ev_n == 6, "R9", "release count", ev_n, 6);
      chk(ev_ptr[4] == 16'h0240 && ev_prio[4] == 1'b0, "R9", "lane 0 first",
          longint'(ev_ptr[4]), 16'h0240);
      chk(ev_ptr[5] == 16'h0200 && ev_prio[5] == 1'b1, "R9", "lane 1 second",
          longint'(ev_ptr[5]), 16'h0200);
      chk(ev_now[5] == 3, "R7", "low lane now", longint'(ev_now[5]), 3);
   endtask

   task automatic t_wrap;
      logic q;
      do_wait(1'b1, 16'h0280, 32'd3 + 32'h7FFF_FFFF, q);
      chk(q == 1'b1, "R4", "max future queued", longint'(q), 1);
      do_wait(1'b1, 16'h02C0, 32'd3 + 32'h8000_0000, q);
      chk(q == 1'b0, "R4", "half range queued", longint'(q), 0);
      for (int i = 0; i < 3; i++) tick(2'b10, 8);
      chk(ev_n == 6, "R4", "release after wrap test", ev_n, 6);
      chk(now_o[63:32] == 6, "R2", "low counter", longint'(now_o[63:32]), 6);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      mem_rdata_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_not_future();
      t_sorted();
      t_lanes();
      t_wrap();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule